// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a four-bank DDR SDRAM and walks the memory from power-on to an operational state. It holds clock enable low while the clock settles for a programmed stabilization time. It then raises clock enable under a NOP, precharges all banks and enables the DLL through the extended mode register. Next it resets the DLL through the base mode register and gives it a counted number of cycles to lock. It precharges again, issues a programmable number of auto-refresh commands and loads the operating mode word. Only after all of that does it raise its done flag.

Every wait in the sequence is served by one shared down-counter. The counter is reloaded on each command cycle with the spacing that the command requires. The operating mode word is formed at elaboration time from parameters for CAS latency, burst length and wrap order. The extended mode word carries the output drive strength choice. A synchronous reset restarts the whole sequence from the clock-enable-low state, at any point in it.

Top module: `ddr_init_seq`

## Requirements
- R1: From reset, mem_cke stays low and the pins carry NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1) for at least CLK_MHZ*STAB_US cycles.
- R2: mem_cke rises on a NOP cycle and then stays high. Every cycle that is not a command cycle carries NOP.
- R3: Commands appear in exactly this order: precharge-all, extended mode write, DLL-reset mode write, precharge-all, N_REFRESH auto-refreshes, operating mode write. The pin codes {cs_n,ras_n,cas_n,we_n} are: precharge 0010, refresh 0001, mode write 0000.
- R4: Each precharge-all drives A10=1, BA=00 and every other address bit 0.
- R5: The extended mode write drives BA=01, A0=0 (DLL enabled) and A1=DRV_HALF (1 selects half drive). All other address bits are 0.
- R6: The DLL-reset mode write drives BA=00, A8=1, and the operating word in A6:A0.
- R7: The final mode write drives BA=00 and A8=0. A2:A0 carries the burst length code (2→001, 4→010, 8→011). A3 is the wrap type (1 for interleave). A6:A4 is the CAS latency code (2→010, 2.5→110, 3→011). All remaining bits are 0.
- R8: Consecutive commands are at least T_MRD (≥2) cycles apart. A command after a precharge comes at least T_RP cycles later. A command after a refresh comes at least T_RFC cycles later. The first command comes at least T_MRD cycles after mem_cke rises.
- R9: The second precharge-all comes at least DLL_LOCK cycles after the DLL-reset mode write.
- R10: Exactly N_REFRESH auto-refresh commands are issued, and N_REFRESH below 2 is rejected at elaboration.
- R11: init_done rises no sooner than T_MRD cycles after the final mode write. It then stays high, and only NOPs follow.
- R12: A synchronous reset, at any point in the sequence, drops mem_cke and init_done on the next edge and replays the full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_cke | output | 1 | Clock enable to the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 2 | Bank address |
| mem_addr | output | AW | Address bus |
| init_done | output | 1 | Sequence complete |

## Verification
The bench builds the block with N_REFRESH=3, so the refresh loop runs past its minimum and the loop exit is exercised away from a trivial count. CAS latency is set to 2.5 with burst 8 and interleaved wrap, and half drive strength is selected. These settings put the least regular CAS code and a set A1 bit on the pins. T_RP=3 and T_RFC=7 are chosen unequal to T_MRD=2, and DLL_LOCK=200, so each spacing rule is checked against its own window. The default 100 MHz × 200 µs stabilization gives a 20000-cycle hold. This keeps three sequences, one of them cut short by a mid-sequence reset, inside the run.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

   // command kinds presented to the pin encoder
   typedef enum logic [1:0] {
      CMD_NOP,
      CMD_PRE_ALL,
      CMD_REFRESH,
      CMD_MODE
   } mem_cmd_e;

   // sequencer states; issue states last exactly one cycle
   typedef enum logic [3:0] {
      ST_PWR_WAIT,
      ST_CKE_UP,
      ST_WAIT,
      ST_PRE1,
      ST_EMRS,
      ST_MRS_DLL,
      ST_PRE2,
      ST_REF,
      ST_MRS_OP,
      ST_DONE
   } seq_state_e;

   // {cs_n, ras_n, cas_n, we_n}
   typedef logic [3:0] cmd_pins_t;

endpackage

// File: rtl/ddr_init_down_ctr.sv
module ddr_init_down_ctr #(
   parameter int CW      = 16,
   parameter int RST_VAL = 0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   output logic          zero_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= CW'(RST_VAL);
      else if (load_i)
         cnt_q <= load_val_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/ddr_init_mode_word.sv
module ddr_init_mode_word #(
   parameter int AW         = 12,
   parameter int CAS_LAT_X2 = 5,
   parameter int BURST_LEN  = 4,
   parameter int INTERLEAVE = 0,
   parameter int DRV_HALF   = 0
) (
   output logic [AW-1:0] op_word_o,
   output logic [AW-1:0] ext_word_o
);

   logic [2:0] cl_code;
   logic [2:0] bl_code;

   if (CAS_LAT_X2 == 4) begin : g_cl2
      assign cl_code = 3'b010;
   end else if (CAS_LAT_X2 == 5) begin : g_cl25
      assign cl_code = 3'b110;
   end else if (CAS_LAT_X2 == 6) begin : g_cl3
      assign cl_code = 3'b011;
   end else begin : g_cl_bad
      $error("CAS_LAT_X2 must be 4, 5 or 6");
      assign cl_code = 3'b000;
   end

   if (BURST_LEN == 2) begin : g_bl2
      assign bl_code = 3'b001;
   end else if (BURST_LEN == 4) begin : g_bl4
      assign bl_code = 3'b010;
   end else if (BURST_LEN == 8) begin : g_bl8
      assign bl_code = 3'b011;
   end else begin : g_bl_bad
      $error("BURST_LEN must be 2, 4 or 8");
      assign bl_code = 3'b000;
   end

   if (INTERLEAVE != 0 && INTERLEAVE != 1) begin : g_wrap_bad
      $error("INTERLEAVE must be 0 or 1");
   end
   if (DRV_HALF != 0 && DRV_HALF != 1) begin : g_drv_bad
      $error("DRV_HALF must be 0 or 1");
   end

   localparam logic WRAP_BIT = (INTERLEAVE != 0);
   localparam logic DRV_BIT  = (DRV_HALF != 0);

   assign op_word_o  = AW'({cl_code, WRAP_BIT, bl_code});
   // A0 low keeps the DLL enabled, A1 picks drive strength
   assign ext_word_o = AW'({DRV_BIT, 1'b0});

endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
   import ddr_init_pkg::*;
(
   input  mem_cmd_e  cmd_i,
   output cmd_pins_t pins_o
);

   always_comb begin
      unique case (cmd_i)
         CMD_PRE_ALL: pins_o = 4'b0010;
         CMD_REFRESH: pins_o = 4'b0001;
         CMD_MODE:    pins_o = 4'b0000;
         default:     pins_o = 4'b0111;
      endcase
   end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
   import ddr_init_pkg::*;
#(
   parameter int AW         = 12,
   parameter int CLK_MHZ    = 100,
   parameter int STAB_US    = 200,
   parameter int T_RP       = 3,
   parameter int T_RFC      = 10,
   parameter int T_MRD      = 2,
   parameter int DLL_LOCK   = 200,
   parameter int N_REFRESH  = 2,
   parameter int CAS_LAT_X2 = 5,
   parameter int BURST_LEN  = 4,
   parameter int INTERLEAVE = 0,
   parameter int DRV_HALF   = 0
) (
   input  logic          clk,
   input  logic          rst,
   output logic          mem_cke,
   output logic          mem_cs_n,
   output logic          mem_ras_n,
   output logic          mem_cas_n,
   output logic          mem_we_n,
   output logic [1:0]    mem_ba,
   output logic [AW-1:0] mem_addr,
   output logic          init_done
);

   localparam int STAB_CYC = CLK_MHZ * STAB_US;
   localparam int LOCK_W   = (DLL_LOCK > T_MRD) ? DLL_LOCK : T_MRD;
   localparam int MAX_A    = (STAB_CYC > LOCK_W) ? STAB_CYC : LOCK_W;
   localparam int MAX_B    = (T_RFC > T_RP) ? T_RFC : T_RP;
   localparam int MAX_W    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CW       = $clog2(MAX_W + 1);
   localparam int RW       = $clog2(N_REFRESH + 1);

   if (AW < 11) begin : g_aw_bad
      $error("AW must reach A10");
   end
   if (N_REFRESH < 2) begin : g_ref_bad
      $error("N_REFRESH must be at least 2");
   end
   if (T_MRD < 2 || T_RP < 2 || T_RFC < 2) begin : g_gap_bad
      $error("command spacing parameters must be at least 2");
   end
   if (STAB_CYC < 1) begin : g_stab_bad
      $error("stabilization time must be nonzero");
   end

   seq_state_e      st_q, ret_q;
   logic [RW-1:0]   ref_q;
   logic            ld;
   logic [CW-1:0]   ld_val;
   logic            wait_zero;
   logic [AW-1:0]   op_word, ext_word;
   mem_cmd_e        cmd;
   cmd_pins_t       pins;

   ddr_init_down_ctr #(
      .CW      (CW),
      .RST_VAL (STAB_CYC - 1)
   ) u_wait (
      .clk        (clk),
      .rst        (rst),
      .load_i     (ld),
      .load_val_i (ld_val),
      .zero_o     (wait_zero)
   );

   ddr_init_mode_word #(
      .AW         (AW),
      .CAS_LAT_X2 (CAS_LAT_X2),
      .BURST_LEN  (BURST_LEN),
      .INTERLEAVE (INTERLEAVE),
      .DRV_HALF   (DRV_HALF)
   ) u_word (
      .op_word_o  (op_word),
      .ext_word_o (ext_word)
   );

   // each issue state loads the spacing it needs; the next issue
   // happens exactly that many cycles later
   always_comb begin
      ld     = 1'b1;
      ld_val = '0;
      unique case (st_q)
         ST_CKE_UP, ST_EMRS, ST_MRS_OP: ld_val = CW'(T_MRD - 2);
         ST_PRE1, ST_PRE2:              ld_val = CW'(T_RP - 2);
         ST_MRS_DLL:                    ld_val = CW'(LOCK_W - 2);
         ST_REF:                        ld_val = CW'(T_RFC - 2);
         default:                       ld     = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= ST_PWR_WAIT;
         ret_q <= ST_PRE1;
         ref_q <= '0;
      end else begin
         unique case (st_q)
            ST_PWR_WAIT: if (wait_zero) st_q <= ST_CKE_UP;
            ST_CKE_UP: begin
               st_q  <= ST_WAIT;
               ret_q <= ST_PRE1;
            end
            ST_PRE1: begin
               st_q  <= ST_WAIT;
               ret_q <= ST_EMRS;
            end
            ST_EMRS: begin
               st_q  <= ST_WAIT;
               ret_q <= ST_MRS_DLL;
            end
            ST_MRS_DLL: begin
               st_q  <= ST_WAIT;
               ret_q <= ST_PRE2;
            end
            ST_PRE2: begin
               st_q  <= ST_WAIT;
               ret_q <= ST_REF;
            end
            ST_REF: begin
               st_q  <= ST_WAIT;
               ref_q <= ref_q + 1'b1;
               ret_q <= (ref_q == RW'(N_REFRESH - 1)) ? ST_MRS_OP : ST_REF;
            end
            ST_MRS_OP: begin
               st_q  <= ST_WAIT;
               ret_q <= ST_DONE;
            end
            ST_WAIT:  if (wait_zero) st_q <= ret_q;
            default:  st_q <= ST_DONE;
         endcase
      end
   end

   always_comb begin
      cmd      = CMD_NOP;
      mem_ba   = 2'b00;
      mem_addr = '0;
      unique case (st_q)
         ST_PRE1, ST_PRE2: begin
            cmd          = CMD_PRE_ALL;
            mem_addr[10] = 1'b1;
         end
         ST_EMRS: begin
            cmd      = CMD_MODE;
            mem_ba   = 2'b01;
            mem_addr = ext_word;
         end
         ST_MRS_DLL: begin
            cmd         = CMD_MODE;
            mem_addr    = op_word;
            mem_addr[8] = 1'b1;
         end
         ST_REF:    cmd = CMD_REFRESH;
         ST_MRS_OP: begin
            cmd      = CMD_MODE;
            mem_addr = op_word;
         end
         default: cmd = CMD_NOP;
      endcase
   end

   ddr_init_cmd_enc u_enc (
      .cmd_i  (cmd),
      .pins_o (pins)
   );

   assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = pins;
   assign mem_cke   = (st_q != ST_PWR_WAIT);
   assign init_done = (st_q == ST_DONE);

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
   parameter int AW    = 12,
   parameter int T_RP  = 3,
   parameter int T_RFC = 10,
   parameter int T_MRD = 2
) (
   input logic          clk,
   input logic          rst,
   input logic          mem_cke,
   input logic          mem_cs_n,
   input logic          mem_ras_n,
   input logic          mem_cas_n,
   input logic          mem_we_n,
   input logic [1:0]    mem_ba,
   input logic [AW-1:0] mem_addr,
   input logic          init_done
);

   logic        is_nop, is_cmd, is_mode;
   logic [15:0] since_q;
   logic        last_pre_q, last_ref_q;

   assign is_nop  = !mem_cs_n && mem_ras_n && mem_cas_n && mem_we_n;
   assign is_cmd  = !is_nop;
   assign is_mode = !mem_cs_n && !mem_ras_n && !mem_cas_n && !mem_we_n;

   always_ff @(posedge clk) begin
      if (rst) begin
         since_q    <= '1;
         last_pre_q <= 1'b0;
         last_ref_q <= 1'b0;
      end else if (is_cmd) begin
         since_q    <= 16'd1;
         last_pre_q <= !mem_ras_n && mem_cas_n && !mem_we_n;
         last_ref_q <= !mem_ras_n && !mem_cas_n && mem_we_n;
      end else if (since_q != '1) begin
         since_q <= since_q + 1'b1;
      end
   end

   // R1
   cke_low_nop_chk: assert property (@(posedge clk) disable iff (rst)
      !mem_cke |-> is_nop);

   // R2
   cke_hold_chk: assert property (@(posedge clk) disable iff (rst)
      mem_cke |=> mem_cke);

   // R8
   cmd_gap_chk: assert property (@(posedge clk) disable iff (rst)
      is_cmd |-> (since_q >= 16'(T_MRD)));

   // R8
   pre_gap_chk: assert property (@(posedge clk) disable iff (rst)
      (is_cmd && last_pre_q) |-> (since_q >= 16'(T_RP)));

   // R8
   ref_gap_chk: assert property (@(posedge clk) disable iff (rst)
      (is_cmd && last_ref_q) |-> (since_q >= 16'(T_RFC)));

   // R5
   ext_fields_chk: assert property (@(posedge clk) disable iff (rst)
      (is_mode && mem_ba == 2'b01) |-> (!mem_addr[0] && mem_addr[AW-1:2] == '0));

   // R11
   done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      init_done |=> init_done);

   // R11
   done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      init_done |-> is_nop);

endmodule

bind ddr_init_seq ddr_init_seq_chk #(
   .AW    (AW),
   .T_RP  (T_RP),
   .T_RFC (T_RFC),
   .T_MRD (T_MRD)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .mem_cke   (mem_cke),
   .mem_cs_n  (mem_cs_n),
   .mem_ras_n (mem_ras_n),
   .mem_cas_n (mem_cas_n),
   .mem_we_n  (mem_we_n),
   .mem_ba    (mem_ba),
   .mem_addr  (mem_addr),
   .init_done (init_done)
);

// File: tb/ddr_init_seq_tb_top.sv
module ddr_init_seq_tb_top;

   localparam int AW        = 12;
   localparam int CLK_MHZ   = 100;
   localparam int STAB_US   = 200;
   localparam int STAB_CYC  = CLK_MHZ * STAB_US;
   localparam int T_RP      = 3;
   localparam int T_RFC     = 7;
   localparam int T_MRD     = 2;
   localparam int DLL_LOCK  = 200;
   localparam int N_REF     = 3;
   localparam int WD_LIMIT  = 150000;

   // CL 2.5 -> 110, interleave -> 1, BL 8 -> 011
   localparam logic [AW-1:0] OP_WORD  = 12'h06B;
   localparam logic [AW-1:0] DLL_WORD = 12'h16B;
   localparam logic [AW-1:0] EXT_WORD = 12'h002;
   localparam logic [AW-1:0] PRE_WORD = 12'h400;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, init_done;
   logic [1:0]    mem_ba;
   logic [AW-1:0] mem_addr;

   always #5 clk = ~clk;

   ddr_init_seq #(
      .AW(AW), .CLK_MHZ(CLK_MHZ), .STAB_US(STAB_US), .T_RP(T_RP),
      .T_RFC(T_RFC), .T_MRD(T_MRD), .DLL_LOCK(DLL_LOCK), .N_REFRESH(N_REF),
      .CAS_LAT_X2(5), .BURST_LEN(8), .INTERLEAVE(1), .DRV_HALF(1)
   ) dut_i (
      .clk(clk), .rst(rst), .mem_cke(mem_cke), .mem_cs_n(mem_cs_n),
      .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
      .mem_ba(mem_ba), .mem_addr(mem_addr), .init_done(init_done)
   );

   typedef struct {
      logic [3:0]    pins;
      logic [1:0]    ba;
      logic [AW-1:0] addr;
      int            min_gap;
      string         req;
      string         gap_req;
   } exp_t;

   exp_t q[$];
   int   n_tests = 0;
   int   n_fail  = 0;
   int   cyc, last_cyc, cmd_cnt, wd_cnt;
   bit   cke_seen, done_seen;
   exp_t e;
   logic [3:0] pins;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic [3:0] p, input logic [1:0] b,
                       input logic [AW-1:0] a, input int g,
                       input string r, input string gr);
      exp_t it;
      it.pins = p; it.ba = b; it.addr = a; it.min_gap = g;
      it.req = r; it.gap_req = gr;
      q.push_back(it);
   endtask

   task automatic push_seq();
      push(4'b0010, 2'b00, PRE_WORD, T_MRD,    "R4", "R8");
      push(4'b0000, 2'b01, EXT_WORD, T_RP,     "R5", "R8");
      push(4'b0000, 2'b00, DLL_WORD, T_MRD,    "R6", "R8");
      push(4'b0010, 2'b00, PRE_WORD, DLL_LOCK, "R4", "R9");
      push(4'b0001, 2'b00, '0,       T_RP,     "R10", "R8");
      for (int i = 1; i < N_REF; i++)
         push(4'b0001, 2'b00, '0,    T_RFC,    "R10", "R8");
      push(4'b0000, 2'b00, OP_WORD,  T_RFC,    "R7", "R8");
   endtask

   // monitor / scoreboard, sampled mid-cycle
   always @(negedge clk) begin
      pins = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
      if (rst) begin
         cyc = 0; last_cyc = 0; cmd_cnt = 0;
         cke_seen = 0; done_seen = 0;
      end else begin
         cyc++;
         if (!cke_seen) begin
            if (mem_cke) begin
               cke_seen = 1;
               last_cyc = cyc;
               chk(cyc - 1 >= STAB_CYC, "R1", "cke low cycles", cyc - 1, STAB_CYC);
               chk(pins == 4'b0111, "R2", "pins at cke rise", pins, 4'b0111);
            end else if (pins != 4'b0111) begin
               chk(0, "R1", "pins while cke low", pins, 4'b0111);
            end
         end else begin
            if (!mem_cke) chk(0, "R2", "cke dropped", 0, 1);
            if (pins != 4'b0111) begin
               cmd_cnt++;
               if (q.size() == 0) begin
                  chk(0, "R3", "unexpected command", pins, 4'b0111);
               end else begin
                  e = q.pop_front();
                  chk(pins == e.pins, "R3", "command order", pins, e.pins);
                  chk(mem_ba == e.ba, e.req, "bank address", mem_ba, e.ba);
                  chk(mem_addr == e.addr, e.req, "address", mem_addr, e.addr);
                  chk(cyc - last_cyc >= e.min_gap, e.gap_req, "gap",
                      cyc - last_cyc, e.min_gap);
               end
               last_cyc = cyc;
            end
         end
         if (init_done && !done_seen) begin
            done_seen = 1;
            chk(q.size() == 0, "R11", "commands left at done", q.size(), 0);
            chk(cyc - last_cyc >= T_MRD, "R11", "done spacing", cyc - last_cyc, T_MRD);
         end else if (done_seen && !init_done) begin
            chk(0, "R11", "done dropped", 0, 1);
         end
      end
   end

   always @(posedge clk) begin
      wd_cnt++;
      if (wd_cnt >= WD_LIMIT) begin
         n_tests++;
         n_fail++;
         $display("FAIL R3 watchdog: actual %0d cycles expected below %0d", wd_cnt, WD_LIMIT);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic apply_reset();
      @(posedge clk); #1 rst = 1'b1;
      q.delete();
      repeat (2) @(posedge clk);
      #1;
      chk(mem_cke == 1'b0, "R12", "cke in reset", mem_cke, 0);
      chk(init_done == 1'b0, "R12", "done in reset", init_done, 0);
      push_seq();
      rst = 1'b0;
   endtask

   initial begin
      wd_cnt = 0;
      repeat (3) @(posedge clk);
      #1;
      chk(mem_cke == 1'b0, "R1", "cke at reset", mem_cke, 0);
      chk(init_done == 1'b0, "R11", "done at reset", init_done, 0);
      push_seq();
      rst = 1'b0;
      wait (init_done);
      repeat (50) @(posedge clk);
      #1;
      chk(init_done == 1'b1, "R11", "done held", init_done, 1);
      chk({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == 4'b0111, "R2",
          "idle pins", {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}, 4'b0111);

      // restart from a finished sequence, then cut it short
      apply_reset();
      wait (cmd_cnt >= 2);
      apply_reset();
      wait (init_done);
      repeat (10) @(posedge clk);
      #1;
      chk(q.size() == 0, "R12", "replayed sequence complete", q.size(), 0);
      chk(init_done == 1'b1, "R12", "done after replay", init_done, 1);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule